// File: doc/BRIEF.md
# Paired-Channel Interrupt Status and Vector Controller

This block gathers interrupt events from eight serial channels. The channels form four blocks of two, and the block drives two interrupt request lines. Each block has an 8-bit status register that is read back and an 8-bit mask register that is written, and both sit at the same register offset. The channel datapath supplies per-channel set and clear strobes for transmit-ready, receive-ready and break. A per-block command strobe clears both break flags of a block.

Each request line is the registered OR of the masked status of two neighbouring blocks. An 8-bit vector register can be loaded from two separate byte-write spaces. An interrupt-acknowledge read space returns the vector for the two valid acknowledge addresses and zero for every other address.

Top module: `paired_irq_ctrl`

## Requirements
- R1: After reset, every status register, every mask register, the vector and both request lines are zero, and every register or acknowledge read returns 0.
- R2: The status flags of channel c live in block c/2. An even channel uses bit 0 (transmit-ready), bit 1 (receive-ready) and bit 2 (break). An odd channel uses bits 4, 5 and 6 for the same three flags. Bits 3 and 7 always read 0.
- R3: While io_rd_i is high and io_addr_i[4:0] equals 0x0A (register offset 0x0B after XOR with 1), io_rdata_o shows the status of block io_addr_i[6:5] in the same cycle. Every other offset reads 0.
- R4: A write with io_wr_i at low address bits 0x0A loads io_wdata_i into the mask of block io_addr_i[6:5] on the next clock edge. Writes at any other offset leave every mask unchanged.
- R5: A set strobe makes its status bit 1 at the next edge. A clear strobe alone makes it 0. When set and clear arrive in the same cycle, the set wins.
- R6: brk_rst_i[b] clears bits 2 and 6 of block b at the next edge, unless a break set strobe for that bit arrives in the same cycle. The other blocks and the other bits are not affected.
- R7: irq_o[0] is high one cycle after (status AND mask) is non-zero in block 0 or block 1. irq_o[1] does the same for blocks 2 and 3. Otherwise the line is low.
- R8: A byte write to address 1 of the ID space (id_wr_i) or of the memory space (mem_wr_i) loads the vector on the next edge. If both arrive in the same cycle, the ID-space write wins. Writes to other addresses are ignored.
- R9: An acknowledge read (ack_rd_i) at address 0 (line 0) or address 2 (line 1) returns the vector in the same cycle. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_set_i | input | 8 | Per-channel transmit-ready set strobe |
| tx_clr_i | input | 8 | Per-channel transmit-ready clear strobe |
| rx_set_i | input | 8 | Per-channel receive-ready set strobe |
| rx_clr_i | input | 8 | Per-channel receive-ready clear strobe |
| brk_set_i | input | 8 | Per-channel break set strobe |
| brk_rst_i | input | 4 | Per-block clear of both break flags |
| io_wr_i | input | 1 | Register write strobe |
| io_rd_i | input | 1 | Register read enable |
| io_addr_i | input | 7 | Register address: block in [6:5], raw offset in [4:0] |
| io_wdata_i | input | 8 | Register write data |
| io_rdata_o | output | 8 | Register read data |
| id_wr_i | input | 1 | ID-space byte write strobe |
| id_addr_i | input | 6 | ID-space address |
| id_wdata_i | input | 8 | ID-space write data |
| mem_wr_i | input | 1 | Memory-space byte write strobe |
| mem_addr_i | input | 23 | Memory-space address |
| mem_wdata_i | input | 8 | Memory-space write data |
| ack_rd_i | input | 1 | Interrupt-acknowledge read enable |
| ack_addr_i | input | 6 | Interrupt-acknowledge address |
| ack_rdata_o | output | 8 | Acknowledge read data (vector or 0) |
| irq_o | output | 2 | Registered interrupt request lines |

## Verification
The bench builds the block with its default parameters: eight channels, four blocks, two request lines, a 7-bit register address, a 6-bit ID and acknowledge address and a 23-bit memory address. With only four blocks, a random block field hits every block and both lines often, so collisions between the lanes of a pair and mask changes on a shared line come up many times in a few thousand cycles. The acknowledge and vector addresses are drawn from small ranges, so the valid addresses 0, 1 and 2 appear often, along with near misses.

// File: rtl/paired_irq_pkg.sv
package paired_irq_pkg;
  localparam int unsigned LANES       = 2;
  localparam int unsigned LANE_STRIDE = 4;
  localparam int unsigned TX_POS      = 0;
  localparam int unsigned RX_POS      = 1;
  localparam int unsigned BRK_POS     = 2;
  localparam int unsigned OFS_W       = 5;
  localparam logic [OFS_W-1:0] STAT_MASK_OFS = 5'h0B;

  // register offsets are byte-swapped on the bus
  function automatic logic [OFS_W-1:0] reg_ofs(input logic [OFS_W-1:0] raw);
    return raw ^ 5'h01;
  endfunction
endpackage

// File: rtl/blk_irq_regs.sv
module blk_irq_regs
  import paired_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] tx_set_i,
  input  logic [LANES-1:0] tx_clr_i,
  input  logic [LANES-1:0] rx_set_i,
  input  logic [LANES-1:0] rx_clr_i,
  input  logic [LANES-1:0] brk_set_i,
  input  logic             brk_rst_i,
  input  logic             imr_we_i,
  input  logic [7:0]       imr_wdata_i,
  output logic [7:0]       isr_o,
  output logic [7:0]       imr_o
);
  logic [7:0] set_v, clr_v, isr_q, imr_q;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int l = 0; l < LANES; l++) begin
      set_v[l*LANE_STRIDE+TX_POS]  = tx_set_i[l];
      set_v[l*LANE_STRIDE+RX_POS]  = rx_set_i[l];
      set_v[l*LANE_STRIDE+BRK_POS] = brk_set_i[l];
      clr_v[l*LANE_STRIDE+TX_POS]  = tx_clr_i[l];
      clr_v[l*LANE_STRIDE+RX_POS]  = rx_clr_i[l];
      clr_v[l*LANE_STRIDE+BRK_POS] = brk_rst_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      imr_q <= '0;
    end else begin
      isr_q <= (isr_q & ~clr_v) | set_v;  // set beats clear
      if (imr_we_i) imr_q <= imr_wdata_i;
    end
  end

  assign isr_o = isr_q;
  assign imr_o = imr_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    AST_TX_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_set_i[l] |=> isr_o[l*LANE_STRIDE+TX_POS]);  // R5
    AST_TX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_clr_i[l] && !tx_set_i[l] |=> !isr_o[l*LANE_STRIDE+TX_POS]);  // R5
    AST_RX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_clr_i[l] && !rx_set_i[l] |=> !isr_o[l*LANE_STRIDE+RX_POS]);  // R5
    AST_BRK_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_rst_i && !brk_set_i[l] |=> !isr_o[l*LANE_STRIDE+BRK_POS]);  // R6
  end

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imr_we_i |=> imr_o == $past(imr_wdata_i));  // R4
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !imr_we_i |=> $stable(imr_o));  // R4
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
  parameter int unsigned NUM_BLK  = 4,
  localparam int unsigned NUM_LINE = NUM_BLK / 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BLK-1:0][7:0]   isr_i,
  input  logic [NUM_BLK-1:0][7:0]   imr_i,
  output logic [NUM_LINE-1:0]       irq_o
);
  logic [NUM_BLK-1:0]  pend;
  logic [NUM_LINE-1:0] line_d, line_q;

  always_comb begin
    for (int b = 0; b < NUM_BLK; b++) pend[b] = |(isr_i[b] & imr_i[b]);
    for (int l = 0; l < NUM_LINE; l++) line_d[l] = pend[2*l] | pend[2*l+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_d;
  end

  assign irq_o = line_q;

  for (genvar l = 0; l < NUM_LINE; l++) begin : g_line_chk
    AST_LINE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(isr_i[2*l] & imr_i[2*l]) || |(isr_i[2*l+1] & imr_i[2*l+1])) |=> irq_o[l]);  // R7
    AST_LINE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|(isr_i[2*l] & imr_i[2*l]) || |(isr_i[2*l+1] & imr_i[2*l+1])) |=> !irq_o[l]);  // R7
  end
endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg #(
  parameter int unsigned ID_ADDR_W  = 6,
  parameter int unsigned MEM_ADDR_W = 23
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  id_wr_i,
  input  logic [ID_ADDR_W-1:0]  id_addr_i,
  input  logic [7:0]            id_wdata_i,
  input  logic                  mem_wr_i,
  input  logic [MEM_ADDR_W-1:0] mem_addr_i,
  input  logic [7:0]            mem_wdata_i,
  output logic [7:0]            vec_o
);
  logic       id_hit, mem_hit;
  logic [7:0] vec_q;

  assign id_hit  = id_wr_i  && (id_addr_i  == ID_ADDR_W'(1));
  assign mem_hit = mem_wr_i && (mem_addr_i == MEM_ADDR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vec_q <= '0;
    else if (id_hit)  vec_q <= id_wdata_i;
    else if (mem_hit) vec_q <= mem_wdata_i;
  end

  assign vec_o = vec_q;

  AST_VEC_ID_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_wr_i && id_addr_i == ID_ADDR_W'(1) |=> vec_o == $past(id_wdata_i));  // R8
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(id_wr_i && id_addr_i == ID_ADDR_W'(1)) && !(mem_wr_i && mem_addr_i == MEM_ADDR_W'(1))
    |=> $stable(vec_o));  // R8
endmodule

// File: rtl/paired_irq_ctrl.sv
module paired_irq_ctrl
  import paired_irq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned ID_ADDR_W  = 6,
  parameter int unsigned MEM_ADDR_W = 23,
  parameter int unsigned ACK_ADDR_W = 6,
  localparam int unsigned NUM_BLK   = NUM_CH / LANES,
  localparam int unsigned NUM_LINE  = NUM_BLK / 2,
  localparam int unsigned BLK_W     = $clog2(NUM_BLK),
  localparam int unsigned IO_ADDR_W = OFS_W + BLK_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CH-1:0]     tx_set_i,
  input  logic [NUM_CH-1:0]     tx_clr_i,
  input  logic [NUM_CH-1:0]     rx_set_i,
  input  logic [NUM_CH-1:0]     rx_clr_i,
  input  logic [NUM_CH-1:0]     brk_set_i,
  input  logic [NUM_BLK-1:0]    brk_rst_i,
  input  logic                  io_wr_i,
  input  logic                  io_rd_i,
  input  logic [IO_ADDR_W-1:0]  io_addr_i,
  input  logic [7:0]            io_wdata_i,
  output logic [7:0]            io_rdata_o,
  input  logic                  id_wr_i,
  input  logic [ID_ADDR_W-1:0]  id_addr_i,
  input  logic [7:0]            id_wdata_i,
  input  logic                  mem_wr_i,
  input  logic [MEM_ADDR_W-1:0] mem_addr_i,
  input  logic [7:0]            mem_wdata_i,
  input  logic                  ack_rd_i,
  input  logic [ACK_ADDR_W-1:0] ack_addr_i,
  output logic [7:0]            ack_rdata_o,
  output logic [NUM_LINE-1:0]   irq_o
);
  logic [NUM_BLK-1:0][7:0] isr, imr;
  logic [BLK_W-1:0]        blk_sel;
  logic                    sm_hit;
  logic [7:0]              vec;
  logic                    ack_ok;

  assign blk_sel = io_addr_i[IO_ADDR_W-1:OFS_W];
  assign sm_hit  = reg_ofs(io_addr_i[OFS_W-1:0]) == STAT_MASK_OFS;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    blk_irq_regs u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tx_set_i    (tx_set_i [b*LANES +: LANES]),
      .tx_clr_i    (tx_clr_i [b*LANES +: LANES]),
      .rx_set_i    (rx_set_i [b*LANES +: LANES]),
      .rx_clr_i    (rx_clr_i [b*LANES +: LANES]),
      .brk_set_i   (brk_set_i[b*LANES +: LANES]),
      .brk_rst_i   (brk_rst_i[b]),
      .imr_we_i    (io_wr_i && sm_hit && (blk_sel == BLK_W'(b))),
      .imr_wdata_i (io_wdata_i),
      .isr_o       (isr[b]),
      .imr_o       (imr[b])
    );
  end

  irq_line_merge #(.NUM_BLK(NUM_BLK)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .isr_i  (isr),
    .imr_i  (imr),
    .irq_o  (irq_o)
  );

  irq_vector_reg #(.ID_ADDR_W(ID_ADDR_W), .MEM_ADDR_W(MEM_ADDR_W)) u_vec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .id_wr_i     (id_wr_i),
    .id_addr_i   (id_addr_i),
    .id_wdata_i  (id_wdata_i),
    .mem_wr_i    (mem_wr_i),
    .mem_addr_i  (mem_addr_i),
    .mem_wdata_i (mem_wdata_i),
    .vec_o       (vec)
  );

  // acknowledge addresses are 2*line
  assign ack_ok      = !ack_addr_i[0] && ((ack_addr_i >> 1) < ACK_ADDR_W'(NUM_LINE));
  assign io_rdata_o  = (io_rd_i && sm_hit) ? isr[blk_sel] : 8'h00;
  assign ack_rdata_o = (ack_rd_i && ack_ok) ? vec : 8'h00;

  AST_ACK_OTHER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd_i && ack_addr_i != '0 && ack_addr_i != ACK_ADDR_W'(2) |-> ack_rdata_o == 8'h00);  // R9
  AST_IO_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && io_addr_i[OFS_W-1:0] != 5'h0A |-> io_rdata_o == 8'h00);  // R3
  AST_SPARE_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i |-> io_rdata_o[3] == 1'b0 && io_rdata_o[7] == 1'b0);  // R2
endmodule

// File: tb/paired_irq_ctrl_test.sv
`timescale 1ns/100ps
module paired_irq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] tx_set, tx_clr, rx_set, rx_clr, brk_set;
  logic [3:0] brk_rst;
  logic io_wr, io_rd;
  logic [6:0] io_addr;
  logic [7:0] io_wdata, io_rdata;
  logic id_wr; logic [5:0] id_addr; logic [7:0] id_wdata;
  logic mem_wr; logic [22:0] mem_addr; logic [7:0] mem_wdata;
  logic ack_rd; logic [5:0] ack_addr; logic [7:0] ack_rdata;
  logic [1:0] irq;

  paired_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_set_i(tx_set), .tx_clr_i(tx_clr), .rx_set_i(rx_set), .rx_clr_i(rx_clr),
    .brk_set_i(brk_set), .brk_rst_i(brk_rst),
    .io_wr_i(io_wr), .io_rd_i(io_rd), .io_addr_i(io_addr), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata),
    .id_wr_i(id_wr), .id_addr_i(id_addr), .id_wdata_i(id_wdata),
    .mem_wr_i(mem_wr), .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata),
    .ack_rd_i(ack_rd), .ack_addr_i(ack_addr), .ack_rdata_o(ack_rdata),
    .irq_o(irq)
  );

  int checks = 0, failures = 0;
  logic [7:0] isr_m [4];
  logic [7:0] imr_m [4];
  logic [7:0] vec_m;
  logic [1:0] irq_m;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    tx_set = 0; tx_clr = 0; rx_set = 0; rx_clr = 0; brk_set = 0; brk_rst = 0;
    io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0;
    id_wr = 0; id_addr = 0; id_wdata = 0;
    mem_wr = 0; mem_addr = 0; mem_wdata = 0;
    ack_rd = 0; ack_addr = 0;
  endtask

  function automatic logic [1:0] line_exp();
    logic [1:0] r;
    for (int l = 0; l < 2; l++)
      r[l] = |(isr_m[2*l] & imr_m[2*l]) || |(isr_m[2*l+1] & imr_m[2*l+1]);
    return r;
  endfunction

  // apply current inputs to the model, clock once, return to idle
  task automatic step();
    irq_m = line_exp();
    for (int c = 0; c < 8; c++) begin
      int b = c / 2;
      int base = (c % 2) * 4;
      if (tx_set[c]) isr_m[b][base] = 1'b1; else if (tx_clr[c]) isr_m[b][base] = 1'b0;
      if (rx_set[c]) isr_m[b][base+1] = 1'b1; else if (rx_clr[c]) isr_m[b][base+1] = 1'b0;
      if (brk_set[c]) isr_m[b][base+2] = 1'b1; else if (brk_rst[b]) isr_m[b][base+2] = 1'b0;
    end
    if (io_wr && io_addr[4:0] == 5'h0A) imr_m[io_addr[6:5]] = io_wdata;
    if (id_wr && id_addr == 6'd1) vec_m = id_wdata;
    else if (mem_wr && mem_addr == 23'd1) vec_m = mem_wdata;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic read_isr(input int b, input string tag);
    io_rd = 1; io_addr = {b[1:0], 5'h0A};
    #0.2 check(tag, io_rdata, isr_m[b]);
    io_rd = 0;
  endtask

  task automatic read_ack(input logic [5:0] a, input string tag);
    ack_rd = 1; ack_addr = a;
    #0.2 check(tag, ack_rdata, (a == 6'd0 || a == 6'd2) ? vec_m : 8'h00);
    ack_rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    idle();
    for (int b = 0; b < 4; b++) begin isr_m[b] = 0; imr_m[b] = 0; end
    vec_m = 0; irq_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int b = 0; b < 4; b++) read_isr(b, "R1 isr reset");
    check("R1 irq reset", irq, 2'b00);
    read_ack(6'd0, "R1 ack reset");
    read_ack(6'd2, "R1 ack reset line1");

    // R2 lane placement
    tx_set[3] = 1; step();
    read_isr(1, "R2 odd tx bit4");
    check("R2 odd tx const", isr_m[1], 8'h10);
    rx_set[2] = 1; brk_set[6] = 1; step();
    read_isr(1, "R2 even rx bit1");
    read_isr(3, "R2 even brk bit2");
    check("R2 even brk const", isr_m[3], 8'h04);

    // R3 wrong offset reads 0
    io_rd = 1; io_addr = {2'd1, 5'h0B};
    #0.2 check("R3 miss offset", io_rdata, 8'h00);
    io_rd = 0;

    // R4 / R7 mask on block 1 drives line 0 after a cycle
    io_wr = 1; io_addr = {2'd1, 5'h0A}; io_wdata = 8'h10; step();
    check("R7 line0 not yet", irq, 2'b00);
    step();
    check("R7 line0 high", irq, 2'b01);
    io_wr = 1; io_addr = {2'd3, 5'h08}; io_wdata = 8'hFF; step(); step();
    check("R4 other offset ignored", irq, 2'b01);
    io_wr = 1; io_addr = {2'd2, 5'h0A}; io_wdata = 8'hFF; step(); step();
    check("R7 line1 via block2 mask needs block2 flag", irq, 2'b01);
    io_wr = 1; io_addr = {2'd3, 5'h0A}; io_wdata = 8'h04; step(); step();
    check("R7 line1 high via block3", irq, 2'b11);

    // R5 set beats clear
    tx_set[0] = 1; tx_clr[0] = 1; step();
    read_isr(0, "R5 set wins");
    check("R5 set wins const", isr_m[0], 8'h01);
    tx_clr[0] = 1; step();
    read_isr(0, "R5 clear");

    // R6 break reset on block 3 only
    brk_set[7] = 1; brk_set[2] = 1; step();
    read_isr(3, "R6 both breaks set");
    brk_rst[3] = 1; step();
    read_isr(3, "R6 block3 breaks cleared");
    check("R6 block3 const", isr_m[3], 8'h00);
    read_isr(1, "R6 block1 untouched");
    step();
    check("R7 line1 drops", irq, 2'b01);

    // R8 / R9 vector
    id_wr = 1; id_addr = 6'd1; id_wdata = 8'hA5; step();
    read_ack(6'd0, "R9 ack line0");
    read_ack(6'd2, "R9 ack line1");
    read_ack(6'd1, "R9 ack other");
    check("R8 id load const", vec_m, 8'hA5);
    id_wr = 1; id_addr = 6'd3; id_wdata = 8'h11; step();
    read_ack(6'd0, "R8 id other ignored");
    mem_wr = 1; mem_addr = 23'd1; mem_wdata = 8'h3C; step();
    read_ack(6'd0, "R8 mem load");
    mem_wr = 1; mem_addr = 23'h101; mem_wdata = 8'h77; step();
    read_ack(6'd2, "R8 mem other ignored");
    id_wr = 1; id_addr = 6'd1; id_wdata = 8'h5A;
    mem_wr = 1; mem_addr = 23'd1; mem_wdata = 8'hC3; step();
    read_ack(6'd0, "R8 id wins");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < 8; c++) begin
        tx_set[c]  = ($urandom_range(7) == 0);
        tx_clr[c]  = ($urandom_range(5) == 0);
        rx_set[c]  = ($urandom_range(7) == 0);
        rx_clr[c]  = ($urandom_range(5) == 0);
        brk_set[c] = ($urandom_range(15) == 0);
      end
      for (int b = 0; b < 4; b++) brk_rst[b] = ($urandom_range(11) == 0);
      io_wr = ($urandom_range(5) == 0);
      io_addr = {2'($urandom_range(3)), ($urandom_range(1) == 0) ? 5'h0A : 5'($urandom_range(31))};
      io_wdata = 8'($urandom_range(255));
      id_wr = ($urandom_range(9) == 0); id_addr = 6'($urandom_range(3)); id_wdata = 8'($urandom_range(255));
      mem_wr = ($urandom_range(9) == 0);
      mem_addr = ($urandom_range(1) == 0) ? 23'd1 : 23'($urandom_range(8));
      mem_wdata = 8'($urandom_range(255));
      step();
      check("R7 random line", irq, irq_m);
      for (int b = 0; b < 4; b++) read_isr(b, "R2 R5 R6 random isr");
      read_ack(6'($urandom_range(5)), "R8 R9 random ack");
      io_rd = 1; io_addr = {2'($urandom_range(3)), 5'($urandom_range(31))};
      #0.2 check("R3 random read", io_rdata,
                 (io_addr[4:0] == 5'h0A) ? isr_m[io_addr[6:5]] : 8'h00);
      io_rd = 0;
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule